// File: doc/BRIEF.md
# Nibble-Coded Register Access Decoder

The decoder sits behind a byte-wide host link and reads a stream of command bytes. The top four bits of each byte are an opcode and the bottom four bits are a payload. A register address is built up from two address-nibble commands. A write byte is built from a data-low command followed by a data-high command, and the write commits when the high nibble arrives. A read command sends the addressed byte back on an output stream that uses valid/ready handshaking. A flag on the read command can step the address forward afterwards, so repeated reads walk through consecutive registers.

Three registers live inside the block:

- An identification byte that always reads 0xA6.
- A scratch byte for link testing.
- A mode byte. Its bit 5 shows a trigger-fired input instead of the stored bit.

Every other address is passed out through a plain external register port. This port connects to the memory and trigger logic, which sit outside this block.

The control is a two-state machine:

- **ACCEPT**: input is accepted (`in_ready` high). Reading a read opcode moves the machine to HOLD. All other opcodes stay in ACCEPT.
- **HOLD**: the read byte is presented on the output. The machine returns to ACCEPT on the cycle after `out_valid && out_ready`.

Top module: `nibble_cmd_decoder`

## Requirements
- R1: A byte is accepted when `in_valid && in_ready`. Opcode 0x0 loads address bits 3:0 from payload bits 3:0. Opcode 0x1 loads address bits 7:4. Each of these leaves the other address nibble unchanged. The current address is always visible on `ext_addr`.
- R2: Opcode 0x2 stores its payload as the pending low data nibble. It causes no register write.
- R3: Opcode 0x3 writes the byte {payload, pending low nibble} to the addressed register in the cycle it is accepted. After the write, the pending low nibble is cleared to 0.
- R4: Writes never move the address. Several data-low/data-high pairs after one address setting all write the same register, in order, and the register ends up holding the last byte.
- R5: Opcode 0x4 is a read. One cycle after it is accepted, `out_valid` is high and `out_byte` holds the addressed register's content as it was on the accepting edge. Exactly one byte is returned per read.
- R6: In a read, payload bit 0 is the next-register flag. When it is 1, the address increments by one after the byte is captured, wrapping from 0xFF to 0x00. When it is 0, the address is unchanged.
- R7: Address 0x00 always reads 0xA6. Writes to it are ignored.
- R8: Address 0x01 reads back the last byte written to it.
- R9: Address 0x02 reads back the last byte written to it, except that bit 5 reports `trig_fired`. `mode_o` presents the written byte.
- R10: For addresses 0x03 to 0xFF, a write pulses `ext_we` for one cycle with the byte on `ext_wdata`, and a read returns `ext_rdata`. Writes to addresses 0x00 to 0x02 never pulse `ext_we`.
- R11: While `out_valid` is high, `in_ready` is low. `out_valid` and `out_byte` hold steady until `out_ready` is high. `in_ready` returns one cycle after the byte is taken.
- R12: Opcodes 0x5 to 0xF are consumed and have no effect on the address, the pending nibble, any register or the output.
- R13: Synchronous active-high reset clears the address, the pending nibble, the scratch and mode registers, and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command byte valid |
| in_byte | input | 8 | Command byte: opcode in 7:4, payload in 3:0 |
| in_ready | output | 1 | Decoder can accept a command byte |
| out_valid | output | 1 | Read byte valid |
| out_byte | output | 8 | Read byte |
| out_ready | input | 1 | Host takes the read byte |
| ext_addr | output | 8 | Current register address |
| ext_wdata | output | 8 | Write byte for an external register |
| ext_we | output | 1 | One-cycle write strobe for addresses 0x03 and up |
| ext_rdata | input | 8 | Read data from the external register at `ext_addr` |
| trig_fired | input | 1 | Trigger status, shown as bit 5 of the mode register |
| mode_o | output | 8 | Stored mode byte |

## Verification
Address and pending-nibble effects appear right after the accepting edge. A write strobe is visible during the accepting cycle itself. A read byte is due one cycle after its command is accepted, so the bench samples on the falling edge that follows acceptance. The bench then holds `out_ready` low for a random number of cycles to confirm that the output stays put, and after the handshake it confirms that `in_ready` returns one cycle later. Internal register contents are checked only through later read commands.

// File: rtl/nibble_cmd_pkg.sv
package nibble_cmd_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    localparam logic [ADDR_W-1:0] ID_ADDR      = 8'h00;
    localparam logic [ADDR_W-1:0] SCRATCH_ADDR = 8'h01;
    localparam logic [ADDR_W-1:0] MODE_ADDR    = 8'h02;
    localparam int                TRIG_BIT     = 5;

    typedef enum logic [NIB_W-1:0] {
        OP_ADR_LO   = 4'h0,
        OP_ADR_HI   = 4'h1,
        OP_DAT_LO   = 4'h2,
        OP_DAT_HI_W = 4'h3,
        OP_READ     = 4'h4
    } opcode_e;

    typedef enum logic {
        ST_ACCEPT = 1'b0,
        ST_HOLD   = 1'b1
    } state_e;
endpackage

// File: rtl/nibble_cmd_fsm.sv
module nibble_cmd_fsm
    import nibble_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_byte,
    input  logic              out_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);
    state_e             state_q, state_d;
    logic [NIB_W-1:0]   op, pay;
    logic [NIB_W-1:0]   lo_q;
    logic               take;

    assign op   = in_byte[DATA_W-1:NIB_W];
    assign pay  = in_byte[NIB_W-1:0];
    assign take = in_valid && (state_q == ST_ACCEPT);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCEPT: if (take && op == OP_READ) state_d = ST_HOLD;
            ST_HOLD:   if (out_ready)             state_d = ST_ACCEPT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ACCEPT;
        else     state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            addr     <= '0;
            lo_q     <= '0;
            out_byte <= '0;
        end else if (take) begin
            case (op)
                OP_ADR_LO:   addr[NIB_W-1:0]      <= pay;
                OP_ADR_HI:   addr[ADDR_W-1:NIB_W] <= pay;
                OP_DAT_LO:   lo_q                 <= pay;
                OP_DAT_HI_W: lo_q                 <= '0;
                OP_READ: begin
                    out_byte <= rd_data;
                    if (pay[0]) addr <= addr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_ACCEPT: in_ready  = 1'b1;
            ST_HOLD:   out_valid = 1'b1;
        endcase
        wr_en   = take && (op == OP_DAT_HI_W);
        wr_data = {pay, lo_q};
    end
endmodule

// File: rtl/nibble_reg_bank.sv
module nibble_reg_bank
    import nibble_cmd_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 8'hA6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trig_fired,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              ext_we,
    output logic [DATA_W-1:0] mode_q
);
    logic [DATA_W-1:0] scratch_q;
    logic              is_local;

    assign is_local = (addr <= MODE_ADDR);
    assign ext_we   = wr_en && !is_local;

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            mode_q    <= '0;
        end else if (wr_en) begin
            if (addr == SCRATCH_ADDR) scratch_q <= wr_data;
            if (addr == MODE_ADDR)    mode_q    <= wr_data;
        end
    end

    always_comb begin
        if (addr == ID_ADDR)           rd_data = ID_VALUE;
        else if (addr == SCRATCH_ADDR) rd_data = scratch_q;
        else if (addr == MODE_ADDR) begin
            rd_data           = mode_q;
            rd_data[TRIG_BIT] = trig_fired;
        end else                       rd_data = ext_rdata;
    end
endmodule

// File: rtl/nibble_cmd_decoder.sv
module nibble_cmd_decoder
    import nibble_cmd_pkg::*;
#(
    parameter logic [7:0] ID_VALUE = 8'hA6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_byte,
    input  logic       out_ready,
    output logic [7:0] ext_addr,
    output logic [7:0] ext_wdata,
    output logic       ext_we,
    input  logic [7:0] ext_rdata,
    input  logic       trig_fired,
    output logic [7:0] mode_o
);
    logic       wr_en;
    logic [7:0] rd_data;

    nibble_cmd_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_ready (out_ready),
        .rd_data   (rd_data),
        .addr      (ext_addr),
        .wr_en     (wr_en),
        .wr_data   (ext_wdata)
    );

    nibble_reg_bank #(.ID_VALUE(ID_VALUE)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .addr       (ext_addr),
        .wr_en      (wr_en),
        .wr_data    (ext_wdata),
        .trig_fired (trig_fired),
        .ext_rdata  (ext_rdata),
        .rd_data    (rd_data),
        .ext_we     (ext_we),
        .mode_q     (mode_o)
    );
endmodule

// File: rtl/nibble_cmd_checker.sv
module nibble_cmd_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_byte,
    input logic       out_ready,
    input logic [7:0] ext_addr,
    input logic       ext_we
);
    logic take;
    assign take = in_valid && in_ready;

    AST_ADDR_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
        take && in_byte[7:4] == 4'h0 |=> ext_addr[3:0] == $past(in_byte[3:0]) && ext_addr[7:4] == $past(ext_addr[7:4])); // R1
    AST_ADDR_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
        take && in_byte[7:4] == 4'h1 |=> ext_addr[7:4] == $past(in_byte[3:0]) && ext_addr[3:0] == $past(ext_addr[3:0])); // R1
    AST_WRITE_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
        take && in_byte[7:4] == 4'h3 |=> $stable(ext_addr)); // R4
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        take && in_byte[7:4] == 4'h4 |=> out_valid); // R5
    AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
        take && in_byte[7:4] == 4'h4 && in_byte[0] |=> ext_addr == $past(ext_addr) + 8'd1); // R6
    AST_EXT_WE_RANGE: assert property (@(posedge clk) disable iff (rst)
        ext_we |-> take && in_byte[7:4] == 4'h3 && ext_addr > 8'h02); // R10
    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R11
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_byte)); // R11
    AST_IGNORED_OP: assert property (@(posedge clk) disable iff (rst)
        take && in_byte[7:4] > 4'h4 |=> $stable(ext_addr) && !out_valid); // R12
endmodule

bind nibble_cmd_decoder nibble_cmd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_ready (out_ready),
    .ext_addr  (ext_addr),
    .ext_we    (ext_we)
);

// File: tb/tb_nibble_cmd_decoder.sv
`timescale 1ns/1ps
module tb_nibble_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_ready;
    logic [7:0] ext_addr;
    logic [7:0] ext_wdata;
    logic       ext_we;
    logic [7:0] ext_rdata;
    logic       trig_fired;
    logic [7:0] mode_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // bench model
    logic [7:0] m_addr, m_scratch, m_mode;
    logic [3:0] m_lo;
    logic       seen_we;
    logic [7:0] seen_wdata, seen_waddr;

    always #5 clk = ~clk;

    assign ext_rdata = ext_addr ^ 8'h3C;

    nibble_cmd_decoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_byte(out_byte),
        .out_ready(out_ready), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_we(ext_we), .ext_rdata(ext_rdata), .trig_fired(trig_fired),
        .mode_o(mode_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        logic [7:0] v;
        if (a == 8'h00)      v = 8'hA6;
        else if (a == 8'h01) v = m_scratch;
        else if (a == 8'h02) begin v = m_mode; v[5] = trig_fired; end
        else                 v = a ^ 8'h3C;
        return v;
    endfunction

    // send one byte and update the model
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        #1;
        seen_we = ext_we; seen_wdata = ext_wdata; seen_waddr = ext_addr;
        @(negedge clk);
        in_valid = 1'b0;
        case (b[7:4])
            4'h0: m_addr[3:0] = b[3:0];
            4'h1: m_addr[7:4] = b[3:0];
            4'h2: m_lo = b[3:0];
            4'h3: begin
                if (m_addr == 8'h01) m_scratch = {b[3:0], m_lo};
                if (m_addr == 8'h02) m_mode    = {b[3:0], m_lo};
                m_lo = 4'h0;
            end
            default: ;
        endcase
    endtask

    task automatic set_addr(input logic [7:0] a);
        send({4'h0, a[3:0]});
        send({4'h1, a[7:4]});
    endtask

    task automatic write_byte(input logic [7:0] d);
        send({4'h2, d[3:0]});
        send({4'h3, d[7:4]});
        if (m_addr > 8'h02) begin
            check("R10 ext_we", seen_we, 1'b1);
            check("R10 ext_wdata", seen_wdata, d);
        end else
            check("R10 no ext_we", seen_we, 1'b0);
    endtask

    task automatic do_read(input bit step, input int stall, input string tag);
        logic [7:0] exp;
        exp = exp_read(m_addr);
        send({4'h4, 3'b000, step});
        check({tag, " R5 out_valid"}, out_valid, 1'b1);
        check({tag, " R5 out_byte"}, out_byte, exp);
        check("R11 in_ready low", in_ready, 1'b0);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check("R11 hold valid", out_valid, 1'b1);
            check("R11 hold byte", out_byte, exp);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R11 released", out_valid, 1'b0);
        check("R11 in_ready back", in_ready, 1'b1);
        if (step) m_addr = m_addr + 8'd1;
        check("R6 addr", ext_addr, m_addr);
    endtask

    initial begin
        #2ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        in_valid = 0; in_byte = 0; out_ready = 0; trig_fired = 0; rst = 1;
        m_addr = 0; m_scratch = 0; m_mode = 0; m_lo = 0;
        seen_we = 0; seen_wdata = 0; seen_waddr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R13 reset state
        check("R13 addr", ext_addr, 8'h00);
        check("R13 out_valid", out_valid, 1'b0);
        check("R13 mode", mode_o, 8'h00);
        check("R13 in_ready", in_ready, 1'b1);
        // R7 identification, write ignored
        do_read(0, 0, "R7 id");
        write_byte(8'h12);
        do_read(0, 1, "R7 id after write");
        // R8 scratch sequence
        set_addr(8'h01);
        write_byte(8'h55);
        do_read(0, 0, "R8 scratch 55");
        write_byte(8'hAA);
        do_read(0, 2, "R8 scratch AA");
        // R3 pending nibble cleared after commit; R2 low alone writes nothing
        send(8'h37);
        do_read(0, 0, "R3 cleared nibble");
        send(8'h29);
        do_read(0, 0, "R2 low only");
        // R4 burst to one address
        set_addr(8'h02);
        write_byte(8'h11); write_byte(8'h3C); write_byte(8'hDF);
        check("R4 R9 mode_o", mode_o, 8'hDF);
        trig_fired = 0; do_read(0, 0, "R9 trig0");
        trig_fired = 1; do_read(0, 0, "R9 trig1");
        // R6 walk and wrap, R1 address nibbles
        set_addr(8'hFD);
        check("R1 addr", ext_addr, 8'hFD);
        for (int i = 0; i < 4; i++) do_read(1, 0, "R6 walk");
        check("R6 wrap", ext_addr, 8'h01);
        // R12 ignored opcodes
        set_addr(8'h01);
        send(8'h2E);
        send(8'h5F); send(8'h9A); send(8'hFF);
        check("R12 addr", ext_addr, 8'h01);
        check("R12 out_valid", out_valid, 1'b0);
        send(8'h36);
        do_read(0, 0, "R12 nibble kept");
        // R10 external
        set_addr(8'h80);
        write_byte(8'h77);
        do_read(0, 0, "R10 ext read");
        // random mix
        for (int n = 0; n < 600; n++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k == 9) trig_fired = ~trig_fired;
            if (k < 2)       send({4'($urandom_range(0, 1)), 4'($urandom_range(0, 15))});
            else if (k < 5)  write_byte(8'($urandom_range(0, 255)));
            else if (k < 8)  do_read(1'($urandom_range(0, 1)), $urandom_range(0, 2), "R5 random");
            else begin
                send({4'($urandom_range(5, 15)), 4'($urandom_range(0, 15))});
                check("R12 random", ext_addr, m_addr);
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule